// File: doc/BRIEF.md
# Programmable Almost-Full / Almost-Empty Flag Unit

This unit sits next to a dual-clock FIFO and turns the FIFO's pointers into two active-low warning flags. `paf_n` warns that the FIFO is close to full and `pae_n` warns that it is close to empty. Each flag has its own programmable margin. The full margin is `m` and the empty margin is `n`. Both margins reset to parameter defaults, and a small parallel write port can overwrite them afterwards.

Two configuration pins are captured while master reset is held low and are ignored after that:
- The fall-through pin selects accounting in which one extra word sits in an output register. This shifts both thresholds up by one word.
- The async pin selects a split-clock style for the almost-full flag. In this style the flag is set on a write-clock edge and cleared on a read-clock edge. In the default style it is a plain register in the write clock domain.

A live retransmit input makes the full side measure the fill level from a marked pointer instead of from the read pointer. The empty side always uses the read pointer.

Pointers are binary counters with AW+1 bits. The fill level is their difference modulo 2^(AW+1). Pointers that cross clock domains are Gray-coded, registered in their source domain, and passed through a two-flop synchroniser.

Top module: `afe_flag_unit`

## Requirements
- R1: While `mrst_n` is low, `paf_n` is 1 and `pae_n` is 0. The margins reset to `DEF_M` (full) and `DEF_N` (empty).
- R2: In standard mode with synchronous timing, `paf_n` is 0 exactly when the full-side level is at least DEPTH−m. A write-pointer change shows on `paf_n` one write-clock edge later.
- R3: In fall-through mode, the almost-full threshold becomes DEPTH+1−m words.
- R4: In standard mode, `pae_n` is 0 exactly when the level (write pointer minus read pointer) is n or less. A read-pointer change shows one read-clock edge later.
- R5: In fall-through mode, `pae_n` is 0 exactly when the level is n+1 or less.
- R6: Cross-domain pointer changes take four destination-clock edges to reach the flag:
  - a change of `rd_ptr` or `mark_ptr` reaches the synchronous `paf_n` after four write-clock edges;
  - a change of `wr_ptr` reaches `pae_n` after four read-clock edges.
  - In both cases the old value still shows after three edges.
- R7: With asynchronous timing, `paf_n` falls on the first write-clock edge at which the level reaches the threshold. It rises on the first read-clock edge at which the level is below the threshold.
- R8: When `retx_en` is 1, the full-side level is `wr_ptr − mark_ptr`. `mark_ptr` never affects `pae_n`.
- R9: When `ofs_we` is 1 on a write-clock edge, `ofs_data` replaces m if `ofs_sel` is 0, or n if `ofs_sel` is 1.
- R10: `async_pin` and `ft_pin` are sampled only while `mrst_n` is low. Later changes on them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| mrst_n | input | 1 | Asynchronous master reset, active low; configuration pins are sampled while it is low |
| async_pin | input | 1 | 1 selects split-clock almost-full timing |
| ft_pin | input | 1 | 1 selects fall-through accounting |
| retx_en | input | 1 | 1 measures the full side from `mark_ptr` |
| wr_ptr | input | AW+1 | Binary write pointer (write domain) |
| rd_ptr | input | AW+1 | Binary read pointer (read domain) |
| mark_ptr | input | AW+1 | Binary retransmit mark (read domain) |
| ofs_we | input | 1 | Margin write strobe (write domain) |
| ofs_sel | input | 1 | 0 selects m, 1 selects n |
| ofs_data | input | AW+1 | Margin value |
| paf_n | output | 1 | Almost-full flag, active low |
| pae_n | output | 1 | Almost-empty flag, active low |

## Verification
A pointer change from the flag's own domain is due one edge later. A pointer change from the other domain is due four edges later, because it passes through the Gray register and two synchroniser flops before the flag register. The exception is the asynchronous almost-full flag, which reacts to either pointer within one edge of its own clock.

The bench changes one pointer at a time and samples one nanosecond after each counted edge. For every cross-domain change it checks the old value at the third edge and the new value at the fourth. A margin write is due one write-clock edge after its strobe. The configuration pins are checked again after they are toggled once reset has been released.

// File: rtl/afe_pkg.sv
`timescale 1ns/1ps
package afe_pkg;

  // Level at or above which the almost-full flag is active.
  function automatic int full_limit(int depth, logic ft, int m);
    return depth + (ft ? 1 : 0) - m;
  endfunction

  // Level at or below which the almost-empty flag is active.
  function automatic int empty_limit(logic ft, int n);
    return n + (ft ? 1 : 0);
  endfunction

endpackage

// File: rtl/afe_ptr_sync.sv
`timescale 1ns/1ps
module afe_ptr_sync #(
  parameter int PW = 5
) (
  input  logic          src_clk,
  input  logic          dst_clk,
  input  logic          rst_n,
  input  logic [PW-1:0] bin_i,
  output logic [PW-1:0] bin_o
);

  function automatic logic [PW-1:0] to_gray(logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] from_gray(logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PW-1:0] gray_src, meta_q, stab_q;

  // Gray register in the source domain.
  always_ff @(posedge src_clk or negedge rst_n) begin
    if (!rst_n) gray_src <= '0;
    else        gray_src <= to_gray(bin_i);
  end

  // Two-flop synchroniser in the destination domain.
  always_ff @(posedge dst_clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= gray_src;
      stab_q <= meta_q;
    end
  end

  assign bin_o = from_gray(stab_q);

endmodule

// File: rtl/afe_ofs_regs.sv
`timescale 1ns/1ps
module afe_ofs_regs #(
  parameter int OW    = 5,
  parameter int DEF_M = 3,
  parameter int DEF_N = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic          sel,
  input  logic [OW-1:0] data,
  output logic [OW-1:0] m_q,
  output logic [OW-1:0] n_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q <= OW'(DEF_M);
      n_q <= OW'(DEF_N);
    end else if (we) begin
      if (sel) n_q <= data;
      else     m_q <= data;
    end
  end

endmodule

// File: rtl/afe_full_side.sv
`timescale 1ns/1ps
module afe_full_side #(
  parameter int DEPTH = 16,
  parameter int PW    = 5,
  parameter int OW    = 5
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          rst_n,
  input  logic          async_mode,
  input  logic          ft_mode,
  input  logic [PW-1:0] wr_ptr,
  input  logic [PW-1:0] ref_sync,
  input  logic [PW-1:0] ref_raw,
  input  logic [OW-1:0] m_ofs,
  output logic          hit_sync,
  output logic          hit_async,
  output logic          paf_n
);
  import afe_pkg::*;

  logic [PW-1:0] lvl_s, lvl_a;
  int            thr;
  logic          paf_q, set_tg, clr_tg, flagged;

  assign lvl_s     = wr_ptr - ref_sync;
  assign lvl_a     = wr_ptr - ref_raw;
  assign thr       = full_limit(DEPTH, ft_mode, int'(m_ofs));
  assign hit_sync  = int'(lvl_s) >= thr;
  assign hit_async = int'(lvl_a) >= thr;

  // Synchronous flag, write domain only.
  always_ff @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n) paf_q <= 1'b1;
    else        paf_q <= !hit_sync;
  end

  // Split-clock flag: toggle pair, active while the two toggles differ.
  assign flagged = set_tg ^ clr_tg;

  always_ff @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n) set_tg <= 1'b0;
    else if (async_mode && !flagged && hit_async) set_tg <= ~set_tg;
  end

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) clr_tg <= 1'b0;
    else if (async_mode && flagged && !hit_async) clr_tg <= ~clr_tg;
  end

  assign paf_n = async_mode ? !flagged : paf_q;

endmodule

// File: rtl/afe_empty_side.sv
`timescale 1ns/1ps
module afe_empty_side #(
  parameter int PW = 5,
  parameter int OW = 5
) (
  input  logic          rd_clk,
  input  logic          rst_n,
  input  logic          ft_mode,
  input  logic [PW-1:0] rd_ptr,
  input  logic [PW-1:0] wr_sync,
  input  logic [OW-1:0] n_ofs,
  output logic          hit,
  output logic          pae_n
);
  import afe_pkg::*;

  logic [PW-1:0] lvl;

  assign lvl = wr_sync - rd_ptr;
  assign hit = int'(lvl) <= empty_limit(ft_mode, int'(n_ofs));

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) pae_n <= 1'b0;
    else        pae_n <= !hit;
  end

endmodule

// File: rtl/afe_flag_unit.sv
`timescale 1ns/1ps
module afe_flag_unit #(
  parameter int AW    = 4,
  parameter int DEF_M = 3,
  parameter int DEF_N = 3
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          mrst_n,
  input  logic          async_pin,
  input  logic          ft_pin,
  input  logic          retx_en,
  input  logic [AW:0]   wr_ptr,
  input  logic [AW:0]   rd_ptr,
  input  logic [AW:0]   mark_ptr,
  input  logic          ofs_we,
  input  logic          ofs_sel,
  input  logic [AW:0]   ofs_data,
  output logic          paf_n,
  output logic          pae_n
);
  localparam int DEPTH = 1 << AW;
  localparam int PW    = AW + 1;
  localparam int OW    = AW + 1;

  logic          async_q, ft_q;
  logic [PW-1:0] ref_raw, ref_sync, wr_sync;
  logic [OW-1:0] m_q, n_q;
  logic          full_hit_s, full_hit_a, empty_hit;

  // Configuration captured only while master reset is held.
  always_ff @(posedge wr_clk) begin
    if (!mrst_n) begin
      async_q <= async_pin;
      ft_q    <= ft_pin;
    end
  end

  assign ref_raw = retx_en ? mark_ptr : rd_ptr;

  afe_ofs_regs #(.OW(OW), .DEF_M(DEF_M), .DEF_N(DEF_N)) u_ofs (
    .clk(wr_clk), .rst_n(mrst_n), .we(ofs_we), .sel(ofs_sel),
    .data(ofs_data), .m_q(m_q), .n_q(n_q)
  );

  afe_ptr_sync #(.PW(PW)) u_ref_sync (
    .src_clk(rd_clk), .dst_clk(wr_clk), .rst_n(mrst_n),
    .bin_i(ref_raw), .bin_o(ref_sync)
  );

  afe_ptr_sync #(.PW(PW)) u_wr_sync (
    .src_clk(wr_clk), .dst_clk(rd_clk), .rst_n(mrst_n),
    .bin_i(wr_ptr), .bin_o(wr_sync)
  );

  afe_full_side #(.DEPTH(DEPTH), .PW(PW), .OW(OW)) u_full (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(mrst_n),
    .async_mode(async_q), .ft_mode(ft_q),
    .wr_ptr(wr_ptr), .ref_sync(ref_sync), .ref_raw(ref_raw),
    .m_ofs(m_q), .hit_sync(full_hit_s), .hit_async(full_hit_a),
    .paf_n(paf_n)
  );

  afe_empty_side #(.PW(PW), .OW(OW)) u_empty (
    .rd_clk(rd_clk), .rst_n(mrst_n), .ft_mode(ft_q),
    .rd_ptr(rd_ptr), .wr_sync(wr_sync), .n_ofs(n_q),
    .hit(empty_hit), .pae_n(pae_n)
  );

endmodule

// File: rtl/afe_flag_chk.sv
`timescale 1ns/1ps
module afe_flag_chk #(
  parameter int OW = 5
) (
  input logic          wr_clk,
  input logic          rd_clk,
  input logic          mrst_n,
  input logic          async_q,
  input logic          ft_q,
  input logic          full_hit_s,
  input logic          full_hit_a,
  input logic          empty_hit,
  input logic          paf_n,
  input logic          pae_n,
  input logic          ofs_we,
  input logic          ofs_sel,
  input logic [OW-1:0] ofs_data,
  input logic [OW-1:0] m_q,
  input logic [OW-1:0] n_q
);

  logic wr_seen, rd_seen;

  always_ff @(posedge wr_clk or negedge mrst_n) begin
    if (!mrst_n) wr_seen <= 1'b0;
    else         wr_seen <= 1'b1;
  end

  always_ff @(posedge rd_clk or negedge mrst_n) begin
    if (!mrst_n) rd_seen <= 1'b0;
    else         rd_seen <= 1'b1;
  end

  AST_SYNC_PAF_TRACKS: assert property (@(posedge wr_clk) disable iff (!mrst_n) (wr_seen && !async_q) |=> (paf_n == !$past(full_hit_s))); // R2
  AST_PAE_TRACKS: assert property (@(posedge rd_clk) disable iff (!mrst_n) rd_seen |=> (pae_n == !$past(empty_hit))); // R4
  AST_M_LOAD: assert property (@(posedge wr_clk) disable iff (!mrst_n) (ofs_we && !ofs_sel) |=> (m_q == $past(ofs_data))); // R9
  AST_N_LOAD: assert property (@(posedge wr_clk) disable iff (!mrst_n) (ofs_we && ofs_sel) |=> (n_q == $past(ofs_data))); // R9
  AST_CFG_HELD: assert property (@(posedge wr_clk) disable iff (!mrst_n) wr_seen |-> ($stable(async_q) && $stable(ft_q))); // R10
  AST_ASYNC_SET_CAUSE: assert property (@(posedge wr_clk) disable iff (!mrst_n) (wr_seen && async_q && $fell(paf_n)) |-> $past(full_hit_a)); // R7

endmodule

bind afe_flag_unit afe_flag_chk #(.OW(AW + 1)) u_chk (
  .wr_clk(wr_clk), .rd_clk(rd_clk), .mrst_n(mrst_n),
  .async_q(async_q), .ft_q(ft_q),
  .full_hit_s(full_hit_s), .full_hit_a(full_hit_a), .empty_hit(empty_hit),
  .paf_n(paf_n), .pae_n(pae_n),
  .ofs_we(ofs_we), .ofs_sel(ofs_sel), .ofs_data(ofs_data),
  .m_q(m_q), .n_q(n_q)
);

// File: tb/sim_afe_flag_unit.sv
`timescale 1ns/1ps
module sim_afe_flag_unit;
  localparam int AW    = 4;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic mrst_n, async_pin, ft_pin, retx_en, ofs_we, ofs_sel;
  logic [AW:0] wr_ptr, rd_ptr, mark_ptr, ofs_data;
  logic paf_n, pae_n;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  afe_flag_unit #(.AW(AW), .DEF_M(3), .DEF_N(3)) u0 (
    .wr_clk(clk), .rd_clk(clk), .mrst_n(mrst_n),
    .async_pin(async_pin), .ft_pin(ft_pin), .retx_en(retx_en),
    .wr_ptr(wr_ptr), .rd_ptr(rd_ptr), .mark_ptr(mark_ptr),
    .ofs_we(ofs_we), .ofs_sel(ofs_sel), .ofs_data(ofs_data),
    .paf_n(paf_n), .pae_n(pae_n)
  );

  task automatic adv(int k);
    repeat (k) @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, string what, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  function automatic logic exp_paf(int lvl, int m, int ft);
    return !(lvl + m >= DEPTH + ft);
  endfunction

  function automatic logic exp_pae(int lvl, int n, int ft);
    return !(lvl <= n + ft);
  endfunction

  task automatic do_reset(logic a, logic f);
    mrst_n = 1'b0; async_pin = a; ft_pin = f; retx_en = 1'b0;
    wr_ptr = '0; rd_ptr = '0; mark_ptr = '0;
    ofs_we = 1'b0; ofs_sel = 1'b0; ofs_data = '0;
    adv(3);
    chk("R1", "paf_n in reset", paf_n, 1'b1);
    chk("R1", "pae_n in reset", pae_n, 1'b0);
    mrst_n = 1'b1;
    adv(1);
  endtask

  task automatic wofs(logic sel, int val);
    ofs_we = 1'b1; ofs_sel = sel; ofs_data = (AW+1)'(val);
    adv(1);
    ofs_we = 1'b0;
  endtask

  initial begin
    int mlist[4] = '{0, 3, 7, 15};
    int nlist[4] = '{0, 5, 1, 16};

    // Defaults and pin capture (R1, R10)
    do_reset(1'b0, 1'b0);
    wr_ptr = 5'd13; adv(1);
    chk("R1", "default m, level 13", paf_n, 1'b0);
    async_pin = 1'b1; ft_pin = 1'b1; adv(2);
    wr_ptr = 5'd12; adv(1);
    chk("R10", "pins ignored, level 12", paf_n, 1'b1);
    wr_ptr = 5'd3; adv(6);
    chk("R1", "default n, level 3", pae_n, 1'b0);
    wr_ptr = 5'd4; adv(6);
    chk("R10", "pins ignored, level 4", pae_n, 1'b1);

    // Retransmit (R8)
    do_reset(1'b0, 1'b0);
    wofs(1'b0, 8); wofs(1'b1, 3);
    wr_ptr = 5'd10; rd_ptr = 5'd8; mark_ptr = 5'd2; retx_en = 1'b1; adv(6);
    chk("R8", "full from mark", paf_n, 1'b0);
    chk("R8", "empty from read ptr", pae_n, 1'b0);
    retx_en = 1'b0; adv(6);
    chk("R8", "full from read ptr", paf_n, 1'b1);
    chk("R8", "empty unchanged", pae_n, 1'b0);

    // Sweep over modes and margins
    for (int fa = 0; fa < 2; fa++) begin
      for (int ff = 0; ff < 2; ff++) begin
        do_reset(fa[0], ff[0]);
        for (int p = 0; p < 4; p++) begin
          int m, n, top;
          string rf, re;
          m = mlist[p]; n = nlist[p]; top = DEPTH + ff;
          rf = (fa != 0) ? "R7" : ((ff != 0) ? "R3" : "R2");
          re = (ff != 0) ? "R5" : "R4";
          wofs(1'b0, m); wofs(1'b1, n);            // R9
          wr_ptr = '0; rd_ptr = '0; adv(6);
          chk(re, "empty at level 0", pae_n, exp_pae(0, n, ff));
          for (int k = 1; k <= top; k++) begin
            wr_ptr = (AW+1)'(k);
            adv(1);
            chk(rf, "full on write", paf_n, exp_paf(k, m, ff));
            adv(2);
            chk("R6", "empty holds at 3rd edge", pae_n, exp_pae(k - 1, n, ff));
            adv(1);
            chk(re, "empty after write", pae_n, exp_pae(k, n, ff));
          end
          for (int j = 1; j <= top; j++) begin
            rd_ptr = (AW+1)'(j);
            adv(1);
            chk(re, "empty on read", pae_n, exp_pae(top - j, n, ff));
            if (fa != 0) chk("R7", "full clears on read edge", paf_n, exp_paf(top - j, m, ff));
            adv(2);
            if (fa == 0) chk("R6", "full holds at 3rd edge", paf_n, exp_paf(top - j + 1, m, ff));
            adv(1);
            chk(rf, "full after read", paf_n, exp_paf(top - j, m, ff));
          end
        end
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule